// File: doc/BRIEF.md
# External Bus Master Cycle Controller

This block is the master side of a simple synchronous external memory and peripheral bus. A host inside the chip asks for a single 16-bit read or write at a word address. The controller then runs that access through a fixed series of bus states. It drives the address, the direction line, a chip select, an output enable and the data lines, and it ends the access on a transfer acknowledge.

The acknowledge can come from the external device on an active-low input. When automatic acknowledge is enabled, an internal counter produces it instead, after a programmed number of wait states. An optional timeout closes a data phase that never gets an acknowledge, and that access is reported with an error flag. Chip select and output enable are released on a falling clock edge in the final state. Address and direction are released on the next rising edge. After a read, the controller waits for a turnaround period before it accepts new work, so it cannot drive the data lines while the previous slave is still letting go of them.

The data lines come out as separate in, out and enable signals, so that the tri-state buffer sits at the pad.

Top module: `ext_bus_master`

## Requirements
- R1: While reset is held, and on the first cycle after it is released: `bus_cs_n`, `bus_oe_n` and `bus_rw_n` are 1, `bus_d_oe` and `bus_adr_oe` are 0, `host_ready` is 1 and `host_done` is 0.
- R2: A request is taken on a rising edge where both `host_req` and `host_ready` are 1. From that edge, `host_ready` is 0, `bus_cs_n` is 0, `bus_adr_oe` is 1, and `bus_addr` holds the requested word address without change for as long as chip select stays low.
- R3: On a read, `bus_oe_n` is 0, `bus_rw_n` is 1 and `bus_d_oe` is 0 for the whole time chip select is low. On a write, `bus_rw_n` is 0, `bus_d_oe` is 1, `bus_d_out` equals the write data and `bus_oe_n` is 1.
- R4: The access has one address cycle, then a data phase of k cycles, then two closing cycles. Chip select is therefore low for k+3 rising-edge samples. With external acknowledge, k is one more than the number of data-phase cycles that pass before `bus_ta_n` is seen low on a rising edge.
- R5: With `cfg_auto_ack` at 1 and `cfg_wait` equal to n, k is n+1 for n from 0 to 15, and `bus_ta_n` has no effect.
- R6: Read data is `bus_d_in` as sampled on the edge that accepts the acknowledge. It is presented on `host_rdata` while `host_done` is 1.
- R7: In the final state, `bus_cs_n` and `bus_oe_n` go to 1 at the falling edge while `bus_adr_oe` is still 1. On the next rising edge, `bus_adr_oe` goes to 0 and `host_done` goes to 1.
- R8: After a read, `host_ready` stays 0 for TURN_CYC cycles (default 2), counted from the cycle in which `host_done` is 1. After a write, `host_ready` is 1 together with `host_done`. `bus_d_oe` is never 1 within two samples of `bus_oe_n` being 0.
- R9: If no acknowledge arrives within TIMEOUT_CYC data-phase cycles (default 32), the data phase ends anyway (k = TIMEOUT_CYC) and `host_err` is 1 with `host_done`. Otherwise `host_err` is 0.
- R10: `host_done` lasts exactly one cycle. A request made while `host_ready` is 0 is ignored: it does not change the bus address and it does not start a second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 23 | Word address |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | Controller idle and able to accept a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with done |
| host_err | output | 1 | Access ended by timeout, valid with done |
| cfg_auto_ack | input | 1 | 1 = internal acknowledge |
| cfg_wait | input | 4 | Wait states for internal acknowledge |
| bus_addr | output | 23 | External word address |
| bus_adr_oe | output | 1 | Address and direction drive enable |
| bus_rw_n | output | 1 | 1 = read, 0 = write |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable to device, active low |
| bus_d_out | output | 16 | Data driven toward the bus |
| bus_d_oe | output | 1 | Data drive enable |
| bus_d_in | input | 16 | Data from the bus |
| bus_ta_n | input | 1 | External transfer acknowledge, active low |

## Verification
An access taken at edge E0 shows its address-phase outputs right after E0. The acknowledge is sampled at edge E1+k, read data is latched on that same edge, and `host_done` rises at edge E0+k+3. Chip select goes high half a cycle before that edge. The bench samples one time unit after each rising edge to count chip-select-low cycles and to check the pins. It samples again just after the falling edge to see the early release, and it drives `bus_ta_n` and `bus_d_in` for data-phase index k-1 only. As a result, any shift by even one cycle in acknowledge sampling or data capture changes a count or a value. The turnaround is measured by counting the cycles in which `host_ready` stays low, starting at the done sample.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_HOLD = 3'd3,
    ST_END  = 3'd4,
    ST_TURN = 3'd5
  } ebm_state_t;
endpackage

// File: rtl/ebm_ack_gen.sv
module ebm_ack_gen #(
  parameter int WAIT_W      = 4,
  parameter int TIMEOUT_CYC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_data,
  input  logic              auto_en,
  input  logic [WAIT_W-1:0] wait_n,
  input  logic              ta_n,
  output logic              ack,
  output logic              timeout
);
  localparam int WMAX = 1 << WAIT_W;
  localparam int LIM  = (TIMEOUT_CYC > WMAX) ? TIMEOUT_CYC : WMAX;
  localparam int CW   = $clog2(LIM + 1);

  logic [CW-1:0] dcnt;

  // data-phase cycle index, restarts whenever the data phase is left
  always_ff @(posedge clk) begin
    if (rst || !in_data) dcnt <= '0;
    else if (dcnt != CW'(LIM)) dcnt <= dcnt + 1'b1;
  end

  assign ack = in_data && (auto_en ? (dcnt == CW'(wait_n)) : !ta_n);

  generate
    if (TIMEOUT_CYC > 0) begin : g_to
      assign timeout = in_data && !ack && (dcnt == CW'(TIMEOUT_CYC - 1));
    end else begin : g_no_to
      assign timeout = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ebm_seq.sv
module ebm_seq
  import ebm_pkg::*;
#(
  parameter int TURN_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       wr_in,
  input  logic       ack,
  input  logic       timeout,
  output ebm_state_t state,
  output ebm_state_t nxt,
  output logic       wr_q
);
  localparam int TCW = $clog2(TURN_CYC + 1);

  logic [TCW-1:0] tcnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req) nxt = ST_ADDR;
      ST_ADDR: nxt = ST_DATA;
      ST_DATA: if (ack || timeout) nxt = ST_HOLD;
      ST_HOLD: nxt = ST_END;
      ST_END:  nxt = wr_q ? ST_IDLE : ST_TURN;
      ST_TURN: if (tcnt == TCW'(TURN_CYC - 1)) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      wr_q  <= 1'b0;
      tcnt  <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && req) wr_q <= wr_in;
      if (state == ST_TURN) tcnt <= tcnt + 1'b1;
      else tcnt <= '0;
    end
  end
endmodule

// File: rtl/ebm_pins.sv
module ebm_pins
  import ebm_pkg::*;
#(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  ebm_state_t    state,
  input  ebm_state_t    nxt,
  input  logic          wr_q,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          ack,
  input  logic          timeout,
  input  logic [DW-1:0] bus_d_in,
  output logic [AW-1:0] bus_addr,
  output logic          bus_adr_oe,
  output logic          bus_rw_n,
  output logic          bus_cs_n,
  output logic          bus_oe_n,
  output logic [DW-1:0] bus_d_out,
  output logic          bus_d_oe,
  output logic          host_ready,
  output logic          host_done,
  output logic [DW-1:0] host_rdata,
  output logic          host_err
);
  logic accept, nxt_active, wr_eff;
  logic cs_q, oe_q, kill_q;

  assign accept     = (state == ST_IDLE) && (nxt == ST_ADDR);
  assign nxt_active = (nxt == ST_ADDR) || (nxt == ST_DATA) ||
                      (nxt == ST_HOLD) || (nxt == ST_END);
  assign wr_eff     = (state == ST_IDLE) ? host_wr : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr   <= '0;
      bus_d_out  <= '0;
      bus_adr_oe <= 1'b0;
      bus_rw_n   <= 1'b1;
      cs_q       <= 1'b1;
      oe_q       <= 1'b1;
      bus_d_oe   <= 1'b0;
      host_ready <= 1'b1;
      host_done  <= 1'b0;
      host_rdata <= '0;
      host_err   <= 1'b0;
    end else begin
      if (accept) begin
        bus_addr  <= host_addr;
        bus_d_out <= host_wdata;
        host_err  <= 1'b0;
      end
      bus_adr_oe <= nxt_active;
      bus_rw_n   <= !(nxt_active && wr_eff);
      cs_q       <= !nxt_active;
      oe_q       <= !(nxt_active && !wr_eff);
      bus_d_oe   <= nxt_active && wr_eff;
      host_ready <= (nxt == ST_IDLE);
      host_done  <= (state == ST_END);
      if (state == ST_DATA && ack && !wr_q) host_rdata <= bus_d_in;
      if (state == ST_DATA && timeout) host_err <= 1'b1;
    end
  end

  // half-cycle early release of select and output enable in the final state
  always_ff @(negedge clk) begin
    if (rst) kill_q <= 1'b0;
    else kill_q <= (state == ST_END);
  end

  assign bus_cs_n = cs_q | kill_q;
  assign bus_oe_n = oe_q | kill_q;
endmodule

// File: rtl/ext_bus_master.sv
module ext_bus_master
  import ebm_pkg::*;
#(
  parameter int AW          = 23,
  parameter int DW          = 16,
  parameter int WAIT_W      = 4,
  parameter int TIMEOUT_CYC = 32,
  parameter int TURN_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [DW-1:0]     host_rdata,
  output logic              host_err,
  input  logic              cfg_auto_ack,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_adr_oe,
  output logic              bus_rw_n,
  output logic              bus_cs_n,
  output logic              bus_oe_n,
  output logic [DW-1:0]     bus_d_out,
  output logic              bus_d_oe,
  input  logic [DW-1:0]     bus_d_in,
  input  logic              bus_ta_n
);
  ebm_state_t state, nxt;
  logic wr_q, ack, timeout, in_data;

  assign in_data = (state == ST_DATA);

  ebm_ack_gen #(.WAIT_W(WAIT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ack (
    .clk(clk), .rst(rst), .in_data(in_data), .auto_en(cfg_auto_ack),
    .wait_n(cfg_wait), .ta_n(bus_ta_n), .ack(ack), .timeout(timeout)
  );

  ebm_seq #(.TURN_CYC(TURN_CYC)) u_seq (
    .clk(clk), .rst(rst), .req(host_req), .wr_in(host_wr), .ack(ack),
    .timeout(timeout), .state(state), .nxt(nxt), .wr_q(wr_q)
  );

  ebm_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst(rst), .state(state), .nxt(nxt), .wr_q(wr_q),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .ack(ack), .timeout(timeout), .bus_d_in(bus_d_in),
    .bus_addr(bus_addr), .bus_adr_oe(bus_adr_oe), .bus_rw_n(bus_rw_n),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_d_out(bus_d_out),
    .bus_d_oe(bus_d_oe), .host_ready(host_ready), .host_done(host_done),
    .host_rdata(host_rdata), .host_err(host_err)
  );
endmodule

// File: rtl/ebm_checker.sv
module ebm_checker #(
  parameter int AW = 23
) (
  input logic          clk,
  input logic          rst,
  input logic          host_req,
  input logic          host_ready,
  input logic          host_done,
  input logic [AW-1:0] bus_addr,
  input logic          bus_adr_oe,
  input logic          bus_rw_n,
  input logic          bus_cs_n,
  input logic          bus_oe_n,
  input logic          bus_d_oe
);
  // R2
  accept_cs_chk: assert property (@(posedge clk) disable iff (rst)
    host_req && host_ready |=> !bus_cs_n && !host_ready && bus_adr_oe);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_cs_n && $past(!bus_cs_n) |-> $stable(bus_addr));

  // R3
  rd_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> bus_rw_n && !bus_d_oe);

  // R3
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    bus_d_oe |-> !bus_rw_n && bus_adr_oe && bus_oe_n);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |-> !bus_adr_oe && bus_cs_n && bus_oe_n);

  // R8
  turn_gap1_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!bus_oe_n) |-> !bus_d_oe);

  // R8
  turn_gap2_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!bus_oe_n, 2) |-> !bus_d_oe);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !host_ready |=> $stable(bus_addr));
endmodule

bind ext_bus_master ebm_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .host_req(host_req), .host_ready(host_ready),
  .host_done(host_done), .bus_addr(bus_addr), .bus_adr_oe(bus_adr_oe),
  .bus_rw_n(bus_rw_n), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
  .bus_d_oe(bus_d_oe)
);

// File: tb/ext_bus_master_bench.sv
module ext_bus_master_bench;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int TO = 32;
  localparam int TC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_ready, host_done, host_err;
  logic [DW-1:0] host_rdata;
  logic cfg_auto_ack = 1'b0;
  logic [3:0] cfg_wait = '0;
  logic [AW-1:0] bus_addr;
  logic bus_adr_oe, bus_rw_n, bus_cs_n, bus_oe_n, bus_d_oe;
  logic [DW-1:0] bus_d_out;
  logic [DW-1:0] bus_d_in = '0;
  logic bus_ta_n = 1'b1;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ext_bus_master #(.AW(AW), .DW(DW), .WAIT_W(4), .TIMEOUT_CYC(TO), .TURN_CYC(TC))
  u_ext_bus_master (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_done(host_done), .host_rdata(host_rdata), .host_err(host_err),
    .cfg_auto_ack(cfg_auto_ack), .cfg_wait(cfg_wait), .bus_addr(bus_addr),
    .bus_adr_oe(bus_adr_oe), .bus_rw_n(bus_rw_n), .bus_cs_n(bus_cs_n),
    .bus_oe_n(bus_oe_n), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
    .bus_d_in(bus_d_in), .bus_ta_n(bus_ta_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // one access; entered and left at one time unit after a rising edge
  task automatic run(input bit wr, input logic [AW-1:0] addr,
                     input logic [DW-1:0] wd, input logic [DW-1:0] rv,
                     input bit auto, input int ws, input int delay,
                     input bit busy);
    int k, cslow, bad, rl, seen;
    bit exp_err;
    logic mid_cs, mid_oe, mid_adr;
    k = auto ? ws + 1 : ((delay < TO) ? delay + 1 : TO);
    exp_err = !auto && (delay >= TO);
    for (int w = 0; w < 100 && !host_ready; w++) begin
      @(posedge clk); #1;
    end
    cfg_auto_ack = auto;
    cfg_wait = 4'(ws);
    host_req = 1'b1; host_wr = wr; host_addr = addr; host_wdata = wd;
    @(posedge clk); #1;
    host_req = busy;
    if (busy) begin host_addr = ~addr; host_wr = ~wr; end
    cslow = 0; bad = 0; seen = 0;
    mid_cs = 1'b0; mid_oe = 1'b0; mid_adr = 1'b0;
    for (int it = 0; it < 200; it++) begin
      int d;
      if (host_done) begin seen = 1; break; end
      if (!bus_cs_n) begin
        cslow++;
        if (bus_addr != addr || !bus_adr_oe) bad++;
        if (wr && (bus_rw_n || !bus_d_oe || bus_d_out != wd || !bus_oe_n)) bad++;
        if (!wr && (!bus_rw_n || bus_d_oe || bus_oe_n)) bad++;
      end
      d = it - 1;
      if (auto) bus_ta_n = !(ws > 0 && d == 0);
      else bus_ta_n = !(d == delay);
      bus_d_in = (d == k - 1) ? rv : ~rv;
      #4;
      mid_cs = bus_cs_n; mid_oe = bus_oe_n; mid_adr = bus_adr_oe;
      @(posedge clk); #1;
    end
    bus_ta_n = 1'b1;
    host_req = 1'b0;
    chk(seen == 1, "R10", "done seen", seen, 1);
    if (auto) chk(cslow == k + 3, "R5", "cs low cycles (auto)", cslow, k + 3);
    else chk(cslow == k + 3, "R4", "cs low cycles (ext)", cslow, k + 3);
    chk(bad == 0, "R3", "pin pattern during cycle", bad, 0);
    if (busy) chk(bad == 0, "R10", "busy request left address", bad, 0);
    chk(mid_cs && mid_oe && mid_adr, "R7", "falling-edge release",
        {mid_cs, mid_oe, mid_adr}, 3'b111);
    chk(!bus_adr_oe && bus_cs_n, "R7", "address released at done",
        {bus_adr_oe, bus_cs_n}, 2'b01);
    chk(host_err == exp_err, "R9", "error flag", host_err, exp_err);
    if (!wr && !exp_err) chk(host_rdata == rv, "R6", "read data", host_rdata, rv);
    if (wr) chk(host_ready == 1'b1, "R8", "ready after write", host_ready, 1);
    rl = host_ready ? 0 : 1;
    @(posedge clk); #1;
    chk(!host_done, "R10", "done one cycle", host_done, 0);
    for (int w = 0; w < 50 && !host_ready; w++) begin
      rl++;
      @(posedge clk); #1;
    end
    if (!wr) chk(rl == TC, "R8", "turnaround cycles", rl, TC);
    if (busy) chk(bus_cs_n && host_ready, "R10", "no second cycle",
                  {bus_cs_n, host_ready}, 2'b11);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(bus_cs_n && bus_oe_n && bus_rw_n && !bus_d_oe && !bus_adr_oe &&
        host_ready && !host_done, "R1", "outputs in reset",
        {bus_cs_n, bus_oe_n, bus_rw_n, bus_d_oe, bus_adr_oe, host_ready, host_done},
        7'b1110010);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(bus_cs_n && bus_oe_n && bus_rw_n && !bus_d_oe && !bus_adr_oe &&
        host_ready && !host_done, "R1", "outputs after reset",
        {bus_cs_n, bus_oe_n, bus_rw_n, bus_d_oe, bus_adr_oe, host_ready, host_done},
        7'b1110010);
    // R5: internal acknowledge, every wait-state value, both directions
    for (int ws = 0; ws < 16; ws++) begin
      run(1'b1, AW'(23'h1234 + ws * 97), DW'(16'hA500 + ws), DW'(0), 1'b1, ws, 0, 1'b0);
      run(1'b0, AW'(23'h7F0F0 ^ ws), DW'(0), DW'(16'h3C00 + ws * 7), 1'b1, ws, 0, 1'b0);
    end
    // R4: external acknowledge at several delays
    for (int dl = 0; dl < 7; dl++) begin
      run(1'b1, AW'(23'h400000 | dl), DW'(16'h5A5A ^ dl), DW'(0), 1'b0, 0, dl, 1'b0);
      run(1'b0, AW'(23'h2AAAA + dl), DW'(0), DW'(16'hC3C3 + dl), 1'b0, 0, dl, 1'b0);
    end
    // R9: no acknowledge at all
    run(1'b1, AW'(23'h55555), DW'(16'h0F0F), DW'(0), 1'b0, 0, 1000, 1'b0);
    run(1'b0, AW'(23'h12345), DW'(0), DW'(16'hBEEF), 1'b0, 0, 1000, 1'b0);
    // R10: request held while busy
    run(1'b1, AW'(23'h00F00), DW'(16'h1111), DW'(0), 1'b1, 3, 0, 1'b1);
    run(1'b0, AW'(23'h3FFFF), DW'(0), DW'(16'h2222), 1'b0, 0, 2, 1'b1);
    // back-to-back read then write: R8 gap
    run(1'b0, AW'(23'h1), DW'(0), DW'(16'hFFFF), 1'b1, 0, 0, 1'b0);
    run(1'b1, AW'(23'h2), DW'(16'h0000), DW'(0), 1'b1, 0, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule